// File: doc/BRIEF.md
# Lithium Cell Charge Sequencer

This block is the digital control core of a single-cell lithium charger. The analog loops, current sensing and threshold comparators sit outside it. The block takes sampled comparator flags and filters each level-based event over a shared timebase tick. It then steps the charge through conditioning, constant-current and taper phases. It commands the current mode and reports progress on two status bits and a power-good bit.

Every phase is guarded by a safety timer. After a timeout fault, the block chooses between two recovery paths from the battery level. One path waits for the battery to sag. The other first drives a small probe current to detect a removed cell. The filter length and all three timer limits are parameters counted in ticks, so a test can shrink hours of charge time to a few hundred cycles.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While reset is applied and directly after it, the block reports sleep: `pgood`=0, `stat1_on`=0, `stat2_on`=0 and `cur_mode`=0. The current-mode code is 0 none, 1 conditioning, 2 constant current, 3 fault probe.
- R2: Each of the five level flags (supply, below-conditioning, below-recharge, below-taper, below-termination) acts only after it has differed from its filtered value for `DG_TICKS` consecutive ticks. A shorter pulse has no effect. With a tick every cycle, an output responds `DG_TICKS`+1 clocks after the input changes.
- R3: When supply is valid and the filtered below-conditioning flag is set, the block drives conditioning current with status 1,1. It moves to constant current with status 1,0 once that flag clears.
- R4: If conditioning lasts `PRE_TICKS` running ticks, the block enters fault with status 0,0.
- R5: If constant current (time spent in the taper phase excluded) lasts `CHG_TICKS` running ticks without termination, the block enters fault with status 0,0.
- R6: A filtered below-taper flag starts a taper timer while the current mode stays 2. The timer is cleared if the flag drops. When the timer reaches `TAP_TICKS`, the charge completes with current 0 and status 0,1.
- R7: A filtered below-termination flag during constant current or taper completes the charge at once, without waiting on the taper timer.
- R8: After completion, a filtered below-recharge flag starts a new charge cycle with cleared timers.
- R9: A fault entered while the battery is above the recharge level keeps current at 0. A new cycle starts when the filtered below-recharge flag sets.
- R10: A fault entered while the battery is below the recharge level drives probe current (mode 3). When the battery rises above the recharge level, the probe stops and the R9 path follows.
- R11: `chg_en_n` high forces current 0 and status 0,0 from the next clock, while `pgood` stays 1. Returning it low starts a fresh cycle, which clears the timers and any fault.
- R12: While `over_temp` is high, the current mode is 0 in the same cycle, the phase and status hold, and the timers stop. Charging resumes where it stopped when the flag clears.
- R13: `usb_sel` encodes 00 as the low rate, 01 as the high rate and 1x as high-Z. With `src_usb`=1, high-Z inhibits charging like R11. `usb_500` is 1 only while charging from USB at the high rate.
- R14: `pgood` follows the filtered supply flag. When supply is lost, the block drops to sleep with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe for filters and timers |
| supply_ok | input | 1 | Adapter or USB supply above battery |
| bat_low | input | 1 | Battery below conditioning threshold |
| bat_below_rch | input | 1 | Battery below recharge threshold |
| i_below_taper | input | 1 | Charge current below taper level |
| i_below_term | input | 1 | Charge current below termination level |
| over_temp | input | 1 | Die over-temperature flag |
| chg_en_n | input | 1 | Active-low charge enable |
| src_usb | input | 1 | Power is taken from the USB input |
| usb_sel | input | 2 | USB rate select: 00 low, 01 high, 1x high-Z |
| chg_on | output | 1 | Charge path enabled |
| cur_mode | output | 2 | 0 none, 1 conditioning, 2 constant current, 3 probe |
| stat1_on | output | 1 | Status bit 1, 1 = drive on |
| stat2_on | output | 1 | Status bit 2, 1 = drive on |
| pgood | output | 1 | Supply valid |
| usb_500 | output | 1 | High USB charge rate in effect |

## Verification
The hardest state to reach from the ports is the probe-current fault. It needs a timeout while the filtered recharge flag still reads low-battery, followed by a rise and a fresh sag across that threshold. The stimulus gets there by holding the conditioning flag until the shortened conditioning timer expires. It then toggles the recharge flag for longer than the filter. Taper timer restart is shown by dropping the taper flag partway through the timer. The bench then confirms that completion comes a full taper period after the second detection, which is later than an uncleared timer would allow.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_OFF,
        ST_PRE,
        ST_FAST,
        ST_TAPER,
        ST_DONE,
        ST_FAULT
    } chg_state_e;

    typedef enum logic [1:0] {
        CUR_NONE  = 2'd0,
        CUR_PRE   = 2'd1,
        CUR_FAST  = 2'd2,
        CUR_PROBE = 2'd3
    } cur_mode_e;

    typedef struct packed {
        logic s1;
        logic s2;
    } stat_t;

    // filtered flag indices
    localparam int NUM_FLT   = 5;
    localparam int F_SUPPLY  = 0;
    localparam int F_LOW     = 1;
    localparam int F_RCH     = 2;
    localparam int F_TAPER   = 3;
    localparam int F_TERM    = 4;
    // reset values: no supply, battery assumed low and below recharge
    localparam logic [NUM_FLT-1:0] FLT_RST = 5'b00110;

    localparam int NUM_TMR = 3;
    localparam int T_PRE   = 0;
    localparam int T_CHG   = 1;
    localparam int T_TAP   = 2;

    localparam logic [1:0] USB_SEL_HIGH = 2'b01;

    function automatic logic usb_inhibit(logic src, logic [1:0] sel);
        return src && sel[1];
    endfunction

    function automatic logic usb_high(logic src, logic [1:0] sel);
        return src && (sel == USB_SEL_HIGH);
    endfunction

    function automatic stat_t status_of(chg_state_e s);
        stat_t r;
        case (s)
            ST_PRE:            r = '{s1: 1'b1, s2: 1'b1};
            ST_FAST, ST_TAPER: r = '{s1: 1'b1, s2: 1'b0};
            ST_DONE:           r = '{s1: 1'b0, s2: 1'b1};
            default:           r = '{s1: 1'b0, s2: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
    parameter int DG_TICKS = 375,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(DG_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            filt <= RST_VAL;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CW'(DG_TICKS - 1)) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
    parameter int LIMIT = 1800
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
    import chg_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FLT-1:0] flt,
    input  logic               hold,
    input  logic               inhibit,
    input  logic [NUM_TMR-1:0] tmr_exp,
    output chg_state_e         state,
    output logic               armed
);
    chg_state_e nxt;
    logic       arm_nxt;
    chg_state_e start_st;

    assign start_st = flt[F_LOW] ? ST_PRE : ST_FAST;

    always_comb begin
        nxt     = state;
        arm_nxt = armed;
        if (!flt[F_SUPPLY]) begin
            nxt = ST_SLEEP;
        end else if (inhibit) begin
            nxt = ST_OFF;
        end else if (!hold) begin
            case (state)
                ST_SLEEP, ST_OFF: nxt = start_st;
                ST_PRE: begin
                    if (tmr_exp[T_PRE]) begin
                        nxt     = ST_FAULT;
                        arm_nxt = !flt[F_RCH];
                    end else if (!flt[F_LOW]) begin
                        nxt = ST_FAST;
                    end
                end
                ST_FAST: begin
                    if (flt[F_TERM]) begin
                        nxt = ST_DONE;
                    end else if (tmr_exp[T_CHG]) begin
                        nxt     = ST_FAULT;
                        arm_nxt = !flt[F_RCH];
                    end else if (flt[F_TAPER]) begin
                        nxt = ST_TAPER;
                    end
                end
                ST_TAPER: begin
                    if (flt[F_TERM] || tmr_exp[T_TAP]) begin
                        nxt = ST_DONE;
                    end else if (!flt[F_TAPER]) begin
                        nxt = ST_FAST;
                    end
                end
                ST_DONE: begin
                    if (flt[F_RCH]) nxt = start_st;
                end
                ST_FAULT: begin
                    if (armed && flt[F_RCH]) begin
                        nxt = start_st;
                    end else if (!flt[F_RCH]) begin
                        arm_nxt = 1'b1;
                    end
                end
                default: nxt = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SLEEP;
            armed <= 1'b0;
        end else begin
            state <= nxt;
            armed <= arm_nxt;
        end
    end
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int DG_TICKS  = 375,
    parameter int PRE_TICKS = 1800000,
    parameter int CHG_TICKS = 18000000,
    parameter int TAP_TICKS = 1800000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       bat_low,
    input  logic       bat_below_rch,
    input  logic       i_below_taper,
    input  logic       i_below_term,
    input  logic       over_temp,
    input  logic       chg_en_n,
    input  logic       src_usb,
    input  logic [1:0] usb_sel,
    output logic       chg_on,
    output logic [1:0] cur_mode,
    output logic       stat1_on,
    output logic       stat2_on,
    output logic       pgood,
    output logic       usb_500
);
    localparam int LIMS [NUM_TMR] = '{PRE_TICKS, CHG_TICKS, TAP_TICKS};

    logic [NUM_FLT-1:0] raw_flt;
    logic [NUM_FLT-1:0] flt;
    logic [NUM_TMR-1:0] tmr_clr;
    logic [NUM_TMR-1:0] tmr_run;
    logic [NUM_TMR-1:0] tmr_exp;
    chg_state_e         state;
    logic               armed;
    logic               inhibit;
    stat_t              st;
    cur_mode_e          cm;

    assign raw_flt[F_SUPPLY] = supply_ok;
    assign raw_flt[F_LOW]    = bat_low;
    assign raw_flt[F_RCH]    = bat_below_rch;
    assign raw_flt[F_TAPER]  = i_below_taper;
    assign raw_flt[F_TERM]   = i_below_term;

    for (genvar i = 0; i < NUM_FLT; i++) begin : g_dg
        chg_deglitch #(
            .DG_TICKS(DG_TICKS),
            .RST_VAL (FLT_RST[i])
        ) u_dg (
            .clk (clk),
            .rst (rst),
            .tick(tick),
            .raw (raw_flt[i]),
            .filt(flt[i])
        );
    end

    assign inhibit = chg_en_n || usb_inhibit(src_usb, usb_sel);

    // timer ownership by phase; constant-current timer survives taper
    assign tmr_clr[T_PRE] = (state != ST_PRE);
    assign tmr_clr[T_CHG] = (state != ST_FAST) && (state != ST_TAPER);
    assign tmr_clr[T_TAP] = (state != ST_TAPER);
    assign tmr_run[T_PRE] = tick && !over_temp && (state == ST_PRE);
    assign tmr_run[T_CHG] = tick && !over_temp && (state == ST_FAST);
    assign tmr_run[T_TAP] = tick && !over_temp && (state == ST_TAPER);

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        chg_timer #(
            .LIMIT(LIMS[t])
        ) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .clr    (tmr_clr[t]),
            .run    (tmr_run[t]),
            .expired(tmr_exp[t])
        );
    end

    chg_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .flt    (flt),
        .hold   (over_temp),
        .inhibit(inhibit),
        .tmr_exp(tmr_exp),
        .state  (state),
        .armed  (armed)
    );

    always_comb begin
        st = status_of(state);
        case (state)
            ST_PRE:            cm = CUR_PRE;
            ST_FAST, ST_TAPER: cm = CUR_FAST;
            ST_FAULT:          cm = armed ? CUR_NONE : CUR_PROBE;
            default:           cm = CUR_NONE;
        endcase
        if (over_temp) cm = CUR_NONE;
    end

    assign cur_mode = cm;
    assign chg_on   = (cm != CUR_NONE);
    assign stat1_on = st.s1;
    assign stat2_on = st.s2;
    assign pgood    = (state != ST_SLEEP);
    assign usb_500  = chg_on && usb_high(src_usb, usb_sel);
endmodule

// File: rtl/chg_seq_ctrl_chk.sv
module chg_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       over_temp,
    input logic       chg_en_n,
    input logic       src_usb,
    input logic [1:0] usb_sel,
    input logic       chg_on,
    input logic [1:0] cur_mode,
    input logic       stat1_on,
    input logic       stat2_on,
    input logic       pgood,
    input logic       usb_500
);
    p_sleep_quiet_r14: assert property (@(posedge clk) disable iff (rst)
        !pgood |-> (cur_mode == 2'd0) && !stat1_on && !stat2_on);

    p_hot_suspend_r12: assert property (@(posedge clk) disable iff (rst)
        over_temp |-> (cur_mode == 2'd0) && !chg_on);

    p_disable_r11: assert property (@(posedge clk) disable iff (rst)
        $past(chg_en_n) |-> (cur_mode == 2'd0));

    p_pre_status_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd1) |-> stat1_on && stat2_on);

    p_fast_status_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd2) |-> stat1_on && !stat2_on);

    p_probe_status_r10: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd3) |-> !stat1_on && !stat2_on);

    p_usb_rate_r13: assert property (@(posedge clk) disable iff (rst)
        usb_500 |-> src_usb && (usb_sel == 2'b01) && chg_on);
endmodule

bind chg_seq_ctrl chg_seq_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .over_temp(over_temp),
    .chg_en_n (chg_en_n),
    .src_usb  (src_usb),
    .usb_sel  (usb_sel),
    .chg_on   (chg_on),
    .cur_mode (cur_mode),
    .stat1_on (stat1_on),
    .stat2_on (stat2_on),
    .pgood    (pgood),
    .usb_500  (usb_500)
);

// File: tb/tb_chg_seq_ctrl.sv
module tb_chg_seq_ctrl;
    localparam int DG  = 4;
    localparam int PRE = 40;
    localparam int CHG = 120;
    localparam int TAP = 30;
    localparam int LAT = DG + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic supply_ok = 1'b0, bat_low = 1'b1, bat_below_rch = 1'b1;
    logic i_below_taper = 1'b0, i_below_term = 1'b0, over_temp = 1'b0;
    logic chg_en_n = 1'b0, src_usb = 1'b0;
    logic [1:0] usb_sel = 2'b00;
    logic chg_on, stat1_on, stat2_on, pgood, usb_500;
    logic [1:0] cur_mode;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chg_seq_ctrl #(
        .DG_TICKS(DG), .PRE_TICKS(PRE), .CHG_TICKS(CHG), .TAP_TICKS(TAP)
    ) dut (
        .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
        .bat_low(bat_low), .bat_below_rch(bat_below_rch),
        .i_below_taper(i_below_taper), .i_below_term(i_below_term),
        .over_temp(over_temp), .chg_en_n(chg_en_n), .src_usb(src_usb),
        .usb_sel(usb_sel), .chg_on(chg_on), .cur_mode(cur_mode),
        .stat1_on(stat1_on), .stat2_on(stat2_on), .pgood(pgood),
        .usb_500(usb_500)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // status as a two-bit number {stat1,stat2}
    function automatic int stv();
        return {stat1_on, stat2_on};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 cur after reset", cur_mode, 0);
        chk("R1 pgood after reset", pgood, 0);
        chk("R1 status after reset", stv(), 0);

        supply_ok = 1'b1;
        cyc(DG);
        chk("R2 pgood before filter done", pgood, 0);
        cyc(1);
        chk("R14 pgood after filter", pgood, 1);
        chk("R3 conditioning mode", cur_mode, 1);
        chk("R3 conditioning status", stv(), 3);

        cyc(PRE - 2);
        chk("R4 still conditioning", cur_mode, 1);
        cyc(4);
        chk("R4 fault status", stv(), 0);
        chk("R10 probe current", cur_mode, 3);

        bat_below_rch = 1'b0;
        cyc(LAT);
        chk("R10 probe stops above recharge", cur_mode, 0);
        bat_below_rch = 1'b1;
        cyc(DG);
        chk("R10 fault held before filter", cur_mode, 0);
        cyc(1);
        chk("R10 new cycle after sag", cur_mode, 1);

        bat_low = 1'b0;
        bat_below_rch = 1'b0;
        cyc(LAT);
        chk("R3 constant current mode", cur_mode, 2);
        chk("R3 constant current status", stv(), 2);

        i_below_term = 1'b1;
        cyc(DG - 1);
        i_below_term = 1'b0;
        cyc(LAT + 1);
        chk("R2 short pulse ignored", cur_mode, 2);

        i_below_taper = 1'b1;
        cyc(LAT);
        chk("R6 taper keeps current", cur_mode, 2);
        cyc(15);
        i_below_taper = 1'b0;
        cyc(LAT);
        i_below_taper = 1'b1;
        cyc(LAT);
        cyc(TAP - 1);
        chk("R6 taper timer restarted", cur_mode, 2);
        cyc(3);
        chk("R6 done current", cur_mode, 0);
        chk("R6 done status", stv(), 1);

        i_below_taper = 1'b0;
        bat_below_rch = 1'b1;
        cyc(LAT);
        chk("R8 recharge restart", cur_mode, 2);

        bat_below_rch = 1'b0;
        i_below_term = 1'b1;
        cyc(DG);
        chk("R7 before filter", cur_mode, 2);
        cyc(1);
        chk("R7 immediate done status", stv(), 1);
        i_below_term = 1'b0;

        bat_below_rch = 1'b1;
        cyc(LAT);
        chk("R8 second restart", cur_mode, 2);
        bat_below_rch = 1'b0;
        cyc(CHG - 2);
        chk("R5 before charge timeout", cur_mode, 2);
        cyc(5);
        chk("R5 fault status", stv(), 0);
        chk("R9 no probe above recharge", cur_mode, 0);

        bat_below_rch = 1'b1;
        cyc(LAT);
        chk("R9 recovery new cycle", cur_mode, 2);

        over_temp = 1'b1;
        cyc(1);
        chk("R12 current off when hot", cur_mode, 0);
        chk("R12 status held", stv(), 2);
        cyc(200);
        over_temp = 1'b0;
        cyc(1);
        chk("R12 resumed, timer held", cur_mode, 2);
        cyc(CHG + 5);
        chk("R5 timeout after resume", stv(), 0);
        chk("R10 probe in second fault", cur_mode, 3);

        chg_en_n = 1'b1;
        cyc(1);
        chk("R11 disabled current", cur_mode, 0);
        chk("R11 disabled status", stv(), 0);
        chk("R11 pgood kept", pgood, 1);
        cyc(3);
        chg_en_n = 1'b0;
        cyc(1);
        chk("R11 fault cleared", cur_mode, 2);
        cyc(CHG - 3);
        chk("R11 timer cleared", cur_mode, 2);

        src_usb = 1'b1;
        usb_sel = 2'b01;
        cyc(1);
        chk("R13 high rate flag", usb_500, 1);
        usb_sel = 2'b00;
        cyc(1);
        chk("R13 low rate flag", usb_500, 0);
        chk("R13 low rate charging", cur_mode, 2);
        usb_sel = 2'b10;
        cyc(1);
        chk("R13 high-Z inhibits", cur_mode, 0);
        usb_sel = 2'b11;
        cyc(1);
        chk("R13 high-Z alt code inhibits", cur_mode, 0);
        usb_sel = 2'b00;
        cyc(1);
        chk("R13 resumes on low rate", cur_mode, 2);
        src_usb = 1'b0;
        usb_sel = 2'b10;
        cyc(1);
        chk("R13 select ignored on adapter", cur_mode, 2);

        supply_ok = 1'b0;
        cyc(DG);
        chk("R14 pgood before filter", pgood, 1);
        cyc(1);
        chk("R14 sleep pgood", pgood, 0);
        chk("R14 sleep status", stv(), 0);
        chk("R14 sleep current", cur_mode, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule